// File: doc/BRIEF.md
# Split Divide-by-Two / Divide-by-Five Decade Counter

This block holds two independent counting lanes. Each lane has a one-bit divide-by-two stage and a three-bit divide-by-five stage. Each stage has its own count strobe, and each strobe is treated as a clock that acts on its falling edge. All of the logic runs on one system clock: a strobe is sampled on that clock, and a sample of high followed by a sample of low counts as one step.

A two-bit mode input sets how each lane's stages are chained:

- In split mode the two stages run apart from each other.
- In decimal mode a fall of the divide-by-two output steps the divide-by-five stage. The lane then counts 0 to 9 in binary.
- In bi-quinary mode the divide-by-five stage takes the input. Each fall of its top bit steps the divide-by-two stage. The divide-by-two output is then a square wave at one tenth of the input rate with a 50% duty cycle.

A chained stage updates one system clock after the stage that drives it. This keeps the order of a ripple counter without clocking any logic from a data signal. A one-clock terminal pulse marks the point where a chained lane returns to zero. Each lane has its own asynchronous reset.

Top module: `dual_decade_counter`

## Requirements
- R1: A stage advances only when its input was sampled high at one rising clock edge and low at the next. The new value appears after that second edge. An input held high or held low causes no further steps.
- R2: On each advance of the divide-by-two stage, the output `qa_o` inverts. It holds its value at all other times.
- R3: The divide-by-five output `quin_o` (bit 2 is the most significant) steps 0,1,2,3,4 and then goes back to 0. Any code above 4 goes to 0 on the next advance.
- R4: While a lane's `rst_i` bit is high, that lane's `qa_o`, `quin_o` and `tc_o` are 0, and strobes have no effect.
- R5: When `mode_i` is 2'b00 or 2'b11 (split mode), the divide-by-two stage counts falls of `strb_a_i` and the divide-by-five stage counts falls of `strb_b_i`.
- R6: When `mode_i` is 2'b01 (decimal mode), `strb_b_i` is ignored. `strb_a_i` drives the divide-by-two stage, and each fall of `qa_o` advances the divide-by-five stage one clock later. After n settled input falls, {quin_o,qa_o} reads n mod 10.
- R7: When `mode_i` is 2'b10 (bi-quinary mode), `strb_a_i` is ignored. `strb_b_i` drives the divide-by-five stage, and each fall of `quin_o[2]` toggles `qa_o` one clock later. After settled falls, {qa_o,quin_o} runs 0,1,2,3,4,8,9,10,11,12 and then repeats.
- R8: In bi-quinary mode, `qa_o` is high for five of every ten settled input falls and low for the other five.
- R9: `tc_o` is high for exactly one clock each time a chained lane returns to zero: in decimal mode when the five-stage wraps, in bi-quinary mode when `qa_o` falls. It is never high in split mode. While `tc_o` is high, the lane's outputs are all zero.
- R10: A change of `mode_i` leaves the stored count unchanged.
- R11: The two lanes are independent. Strobes, mode and reset of one lane do not affect the other lane.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | NUM_LANES | Asynchronous active-high clear, one bit per lane |
| mode_i | input | NUM_LANES x 2 | Chaining mode per lane |
| strb_a_i | input | NUM_LANES | Count strobe for the divide-by-two stage |
| strb_b_i | input | NUM_LANES | Count strobe for the divide-by-five stage |
| qa_o | output | NUM_LANES | Divide-by-two stage output |
| quin_o | output | NUM_LANES x 3 | Divide-by-five stage output, bit 2 most significant |
| tc_o | output | NUM_LANES | One-clock terminal pulse on return to zero |

## Verification
Some properties are checked by the assertions on every clock:

- the single-step behaviour of each stage: toggle, hold, step, wrap and the code range;
- the clear under reset;
- that the terminal pulse lasts one clock and only appears on an all-zero state.

Other behaviour needs the bench's scenarios to show it:

- the full counting sequences of the two chained modes, and the half-on, half-off shape of the bi-quinary square wave;
- that the idle strobe is ignored in each chained mode;
- that the count survives a change of mode;
- that the two lanes stay apart.

// File: rtl/decade_pkg.sv
package decade_pkg;

    localparam int QUIN_W = 3;
    localparam logic [QUIN_W-1:0] QUIN_LAST = 3'd4;

    typedef enum logic [1:0] {
        CM_SPLIT   = 2'b00,
        CM_DECIMAL = 2'b01,
        CM_BIQ     = 2'b10,
        CM_SPARE   = 2'b11
    } cnt_mode_e;

    // stage advance requests for one lane
    typedef struct packed {
        logic adv_two;
        logic adv_five;
    } adv_t;

    // next code of the divide-by-five stage; unused codes fold to zero
    function automatic logic [QUIN_W-1:0] quin_next(input logic [QUIN_W-1:0] cur);
        return (cur >= QUIN_LAST) ? '0 : cur + 1'b1;
    endfunction

endpackage

// File: rtl/fall_sense.sv
module fall_sense #(
    parameter int W = 4
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] sig_i,
    output logic [W-1:0] fall_o
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) prev_q <= '0;
        else       prev_q <= sig_i;
    end

    assign fall_o = prev_q & ~sig_i;

endmodule

// File: rtl/tog_stage.sv
module tog_stage (
    input  logic clk_i,
    input  logic rst_i,
    input  logic adv_i,
    output logic qa_o
);
    logic qa_q;

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i)      qa_q <= 1'b0;
        else if (adv_i) qa_q <= ~qa_q;
    end

    assign qa_o = qa_q;

    AST_QA_TOGGLE: assert property (@(posedge clk_i) disable iff (rst_i)
        adv_i |=> (qa_q != $past(qa_q)));                          // R2
    AST_QA_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        !adv_i |=> $stable(qa_q));                                 // R2

endmodule

// File: rtl/quin_stage.sv
module quin_stage
    import decade_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              adv_i,
    output logic [QUIN_W-1:0] cnt_o
);
    logic [QUIN_W-1:0] cnt_q;

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i)      cnt_q <= '0;
        else if (adv_i) cnt_q <= quin_next(cnt_q);
    end

    assign cnt_o = cnt_q;

    AST_QUIN_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
        cnt_q <= QUIN_LAST);                                       // R3
    AST_QUIN_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
        (adv_i && cnt_q < QUIN_LAST) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R3
    AST_QUIN_WRAP: assert property (@(posedge clk_i) disable iff (rst_i)
        (adv_i && cnt_q == QUIN_LAST) |=> (cnt_q == '0));          // R3
    AST_QUIN_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        !adv_i |=> $stable(cnt_q));                                // R3

endmodule

// File: rtl/decade_lane.sv
module decade_lane
    import decade_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [1:0]        mode_i,
    input  logic              strb_a_i,
    input  logic              strb_b_i,
    output logic              qa_o,
    output logic [QUIN_W-1:0] quin_o,
    output logic              tc_o
);
    localparam int N_SRC = 4;

    cnt_mode_e         mode;
    logic [N_SRC-1:0]  src;
    logic [N_SRC-1:0]  fall;
    adv_t              adv;
    logic              qa;
    logic [QUIN_W-1:0] quin;
    logic              tc_q;

    assign mode = cnt_mode_e'(mode_i);
    // bit order: strobe a, strobe b, two-stage output, five-stage top bit
    assign src  = {quin[QUIN_W-1], qa, strb_b_i, strb_a_i};

    fall_sense #(.W(N_SRC)) u_fall (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .sig_i  (src),
        .fall_o (fall)
    );

    always_comb begin
        unique case (mode)
            CM_DECIMAL: begin
                adv.adv_two  = fall[0];
                adv.adv_five = fall[2];
            end
            CM_BIQ: begin
                adv.adv_two  = fall[3];
                adv.adv_five = fall[1];
            end
            default: begin
                adv.adv_two  = fall[0];
                adv.adv_five = fall[1];
            end
        endcase
    end

    tog_stage u_two (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .adv_i (adv.adv_two),
        .qa_o  (qa)
    );

    quin_stage u_five (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .adv_i (adv.adv_five),
        .cnt_o (quin)
    );

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) tc_q <= 1'b0;
        else       tc_q <= ((mode == CM_DECIMAL) && adv.adv_five && (quin == QUIN_LAST))
                        || ((mode == CM_BIQ) && adv.adv_two && qa);
    end

    assign qa_o   = qa;
    assign quin_o = quin;
    assign tc_o   = tc_q;

    AST_RST_CLEAR: assert property (@(posedge clk_i)
        rst_i |-> (!qa && quin == '0 && !tc_q));                  // R4
    AST_TC_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
        tc_q |-> (!qa && quin == '0));                             // R9
    AST_TC_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
        tc_q |=> !tc_q);                                           // R9

endmodule

// File: rtl/dual_decade_counter.sv
module dual_decade_counter
    import decade_pkg::*;
#(
    parameter int NUM_LANES = 2
) (
    input  logic                              clk_i,
    input  logic [NUM_LANES-1:0]              rst_i,
    input  logic [NUM_LANES-1:0][1:0]         mode_i,
    input  logic [NUM_LANES-1:0]              strb_a_i,
    input  logic [NUM_LANES-1:0]              strb_b_i,
    output logic [NUM_LANES-1:0]              qa_o,
    output logic [NUM_LANES-1:0][QUIN_W-1:0]  quin_o,
    output logic [NUM_LANES-1:0]              tc_o
);
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        decade_lane u_lane (
            .clk_i    (clk_i),
            .rst_i    (rst_i[g]),
            .mode_i   (mode_i[g]),
            .strb_a_i (strb_a_i[g]),
            .strb_b_i (strb_b_i[g]),
            .qa_o     (qa_o[g]),
            .quin_o   (quin_o[g]),
            .tc_o     (tc_o[g])
        );
    end

endmodule

// File: tb/dual_decade_counter_tb.sv
`timescale 1ns/1ps
module dual_decade_counter_tb;

    logic            clk = 1'b0;
    logic [1:0]      rst = 2'b11;
    logic [1:0][1:0] mode = '0;
    logic [1:0]      strb_a = '0;
    logic [1:0]      strb_b = '0;
    logic [1:0]      qa;
    logic [1:0][2:0] quin;
    logic [1:0]      tc;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;
    int tc_seen [2] = '{0, 0};

    dual_decade_counter #(.NUM_LANES(2)) u_dut (
        .clk_i    (clk),
        .rst_i    (rst),
        .mode_i   (mode),
        .strb_a_i (strb_a),
        .strb_b_i (strb_b),
        .qa_o     (qa),
        .quin_o   (quin),
        .tc_o     (tc)
    );

    always #4 clk = ~clk;

    always @(negedge clk) begin
        for (int l = 0; l < 2; l++) tc_seen[l] += int'(tc[l]);
    end

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // one strobe fall on the selected lanes, then settle
    task automatic pulse(input logic [1:0] am, input logic [1:0] bm);
        @(negedge clk);
        strb_a = am;
        strb_b = bm;
        @(negedge clk);
        strb_a = '0;
        strb_b = '0;
        repeat (3) @(negedge clk);
    endtask

    task automatic clear(input logic [1:0] m);
        @(negedge clk);
        rst = rst | m;
        repeat (2) @(negedge clk);
        rst = rst & ~m;
        @(negedge clk);
    endtask

    // expected {quin,qa} from the requirements
    function automatic logic [3:0] expect_state(input logic [1:0] m, input int na, input int nb);
        int k;
        case (m)
            2'b01: begin
                k = na % 10;
                return 4'(k);
            end
            2'b10: begin
                k = nb % 10;
                return {3'(k % 5), (k >= 5)};
            end
            default: return {3'(nb % 5), 1'(na % 2)};
        endcase
    endfunction

    function automatic int expect_tc(input logic [1:0] m, input int na, input int nb);
        if (m == 2'b01) return na / 10;
        if (m == 2'b10) return nb / 10;
        return 0;
    endfunction

    function automatic int lane_state(input int l);
        return int'({quin[l], qa[l]});
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int base;
        int highs;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R4: outputs clear while held, strobes ignored
        chk("R4 reset qa", int'(qa), 0);
        chk("R4 reset quin", int'(quin), 0);
        pulse(2'b11, 2'b11);
        chk("R4 strobes under reset", lane_state(0) + lane_state(1) + int'(tc), 0);
        rst = 2'b00;
        @(negedge clk);

        // R1/R2: a held-high strobe does not count until it falls
        @(negedge clk); strb_a[0] = 1'b1;
        repeat (6) @(negedge clk);
        chk("R1 held high no step", int'(qa[0]), 0);
        strb_a[0] = 1'b0;
        repeat (3) @(negedge clk);
        chk("R2 toggle on fall", int'(qa[0]), 1);
        repeat (6) @(negedge clk);
        chk("R1 held low no step", int'(qa[0]), 1);

        // R5/R3: split mode, and mode 2'b11 behaves the same
        clear(2'b01);
        for (int i = 0; i < 7; i++) pulse(2'b01, 2'b01);
        chk("R3 R5 split 7 edges", lane_state(0), int'(expect_state(2'b00, 7, 7)));
        mode[0] = 2'b11;
        clear(2'b01);
        base = tc_seen[0];
        for (int i = 0; i < 3; i++) pulse(2'b01, 2'b00);
        for (int i = 0; i < 9; i++) pulse(2'b00, 2'b01);
        chk("R5 spare mode", lane_state(0), int'(expect_state(2'b00, 3, 9)));
        chk("R9 no pulse split", tc_seen[0] - base, 0);

        // R6: decimal walk, b strobe ignored, R9 pulses
        mode[0] = 2'b01;
        clear(2'b01);
        base = tc_seen[0];
        for (int n = 1; n <= 20; n++) begin
            pulse(2'b01, 2'b00);
            chk("R6 decimal seq", lane_state(0), n % 10);
        end
        chk("R9 decimal wraps", tc_seen[0] - base, 2);
        pulse(2'b00, 2'b01);
        chk("R6 b ignored", lane_state(0), 0);

        // R7/R8: bi-quinary walk, a strobe ignored
        mode[0] = 2'b10;
        clear(2'b01);
        base = tc_seen[0];
        highs = 0;
        for (int n = 1; n <= 20; n++) begin
            pulse(2'b00, 2'b01);
            chk("R7 biquinary seq", int'({qa[0], quin[0]}),
                ((n % 10) < 5) ? (n % 10) : (n % 10) + 3);
            if (n <= 10) highs += int'(qa[0]);
        end
        chk("R8 half duty", highs, 5);
        chk("R9 biquinary wraps", tc_seen[0] - base, 2);
        pulse(2'b01, 2'b00);
        chk("R7 a ignored", lane_state(0), 0);

        // R10: mode change keeps count
        mode[0] = 2'b01;
        clear(2'b01);
        for (int i = 0; i < 7; i++) pulse(2'b01, 2'b00);
        @(negedge clk); mode[0] = 2'b10;
        repeat (3) @(negedge clk);
        chk("R10 to biquinary", lane_state(0), 7);
        @(negedge clk); mode[0] = 2'b00;
        repeat (3) @(negedge clk);
        chk("R10 to split", lane_state(0), 7);

        // R11: lanes independent
        mode = {2'b10, 2'b01};
        clear(2'b11);
        for (int i = 0; i < 4; i++) pulse(2'b01, 2'b10);
        clear(2'b01);
        chk("R11 lane0 cleared", lane_state(0), 0);
        chk("R11 lane1 kept", int'({qa[1], quin[1]}), 4);

        // random rounds
        for (int r = 0; r < 25; r++) begin
            int na [2];
            int nb [2];
            int tb [2];
            int mx;
            logic [1:0] am;
            logic [1:0] bm;
            mx = 0;
            for (int l = 0; l < 2; l++) begin
                mode[l] = 2'($urandom_range(0, 3));
                na[l] = int'($urandom_range(0, 24));
                nb[l] = int'($urandom_range(0, 24));
                if (na[l] > mx) mx = na[l];
                if (nb[l] > mx) mx = nb[l];
            end
            clear(2'b11);
            for (int l = 0; l < 2; l++) tb[l] = tc_seen[l];
            for (int i = 0; i < mx; i++) begin
                for (int l = 0; l < 2; l++) begin
                    am[l] = (i < na[l]);
                    bm[l] = (i < nb[l]);
                end
                pulse(am, bm);
            end
            for (int l = 0; l < 2; l++) begin
                chk("R5 R6 R7 R11 random state", lane_state(l),
                    int'(expect_state(mode[l], na[l], nb[l])));
                chk("R9 random pulses", tc_seen[l] - tb[l],
                    expect_tc(mode[l], na[l], nb[l]));
            end
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule